// File: doc/BRIEF.md
# PDM Microphone Output Controller

This block is the digital back end of a single-bit audio microphone. A modulator stream enters one bit per period of an externally supplied bit clock. The block places that stream on a shared serial data line that can be released to high impedance. An edge-select input decides which half of each bit-clock period belongs to this device. Two devices can therefore interleave their samples on one wire: one drives after the rising edge, the other after the falling edge.

Power state is taken only from the bit clock itself. A monitor running on a free-running reference clock counts synchronized bit-clock rising edges over a fixed window. It wakes the device when the edge rate reaches the wake threshold. It puts the device to sleep when the rate drops to the sleep threshold or below, which includes a clock held still. Between the two thresholds the state does not change. After each wake the line is driven low for a set number of bit-clock periods while the modulator settles, and live data follows. The modulator-enable output follows the power state.

Top module: `pdm_out_ctrl`

## Requirements
- R1: While reset is asserted and directly after its release, `mod_en` and `pdm_oe` are both 0.
- R2: A monitor window of WIN_US microseconds that holds at least WAKE_KHZ*WIN_US/1000 bit-clock rising edges (12 by default, equal to 300 kHz) wakes the device. `mod_en` rises at the end of that window.
- R3: A window that holds at most SLEEP_KHZ*WIN_US/1000 rising edges (2 by default, equal to 70 kHz, and including a stopped clock) puts the device to sleep. In the same reference cycle `mod_en` drops to 0 and `pdm_oe` drops to 0.
- R4: A window whose edge count lies strictly between the two thresholds leaves the power state as it was, whether the device is awake or asleep.
- R5: With the latched edge select at 0, the line is driven after each falling edge of `bclk` and released after each rising edge.
- R6: With the latched edge select at 1, the line is driven after each rising edge of `bclk` and released after each falling edge.
- R7: After a wake, the first MUTE_CYC periods in which the line is driven carry 0 whatever `mod_bit` is. Live data follows from then on.
- R8: `sel` is latched only during reset and while asleep. A change of `sel` while awake has no effect on ownership until the next sleep.
- R9: Once the mute has ended, each driven period carries the `mod_bit` value present at the owning `bclk` edge that started it. There is one modulator bit per bit-clock period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock for the activity monitor |
| rst_n | input | 1 | Synchronous active-low reset, seen in both clock domains |
| bclk | input | 1 | Externally supplied bit clock |
| sel | input | 1 | Edge select: 0 owns the falling-edge half, 1 owns the rising-edge half |
| mod_bit | input | 1 | One-bit modulator output |
| mod_en | output | 1 | Modulator enable, high while awake |
| pdm_dat | output | 1 | Serial data value toward the shared line, 0 when released |
| pdm_oe | output | 1 | Drive enable for the shared line, 0 means high impedance |

## Verification
The edge-ownership properties assume that `bclk` is slow against the reference clock and that it comes to rest low while `sel` changes. The first edge after a change of `sel` is exempt, because that edge finds the old marks. The stimulus keeps each bit-clock half period at 125 ns or longer and switches `sel` only while the clock is running and the device is awake, or while the clock is parked low. Edge rates are picked well away from both thresholds (400 kHz and up, 150 kHz, 25 kHz, stopped), so window alignment cannot move a count across a threshold. `mod_bit` changes only in the middle of the non-owning half.

// File: rtl/pdm_out_pkg.sv
// Package: shared types and helpers for the PDM output controller.
// Assumes rates are given in kHz and windows in microseconds.
package pdm_out_pkg;

    typedef enum logic {
        PWR_SLEEP = 1'b0,
        PWR_AWAKE = 1'b1
    } pwr_state_t;

    // Converts an edge rate in kHz into edges per monitor window.
    function automatic int unsigned rate_to_edges(input int unsigned khz,
                                                  input int unsigned win_us);
        return (khz * win_us) / 1000;
    endfunction

endpackage

// File: rtl/pdm_clk_monitor.sv
// Module: bit-clock activity monitor in the reference-clock domain.
// Synchronizes bclk, counts its rising edges over a fixed window and
// applies wake/sleep thresholds with hysteresis. The edge select is
// latched here during reset and while asleep.
// Assumes: bclk frequency below half of ref_clk frequency.
module pdm_clk_monitor
    import pdm_out_pkg::*;
#(
    parameter int unsigned REF_KHZ     = 50000,
    parameter int unsigned WIN_US      = 40,
    parameter int unsigned WAKE_KHZ    = 300,
    parameter int unsigned SLEEP_KHZ   = 70,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic sel,
    output logic awake,
    output logic sel_lat,
    output logic win_end
);

    localparam int unsigned WIN_LEN   = (REF_KHZ * WIN_US) / 1000;
    localparam int unsigned WIN_W     = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int unsigned EDGE_W    = $clog2(WIN_LEN + 1);
    localparam int unsigned WAKE_CNT  = rate_to_edges(WAKE_KHZ, WIN_US);
    localparam int unsigned SLEEP_CNT = rate_to_edges(SLEEP_KHZ, WIN_US);

    logic [SYNC_STAGES:0]  bsync_q;
    logic [SYNC_STAGES-1:0] ssync_q;
    logic                  bclk_rise;
    logic [WIN_W-1:0]      win_q;
    logic [EDGE_W-1:0]     edge_q;
    logic [EDGE_W:0]       edge_total;
    pwr_state_t            state_q;
    pwr_state_t            state_d;

    // Shift chain that brings bclk and sel into the reference domain.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            bsync_q <= '0;
            ssync_q <= '0;
        end else begin
            bsync_q <= {bsync_q[SYNC_STAGES-1:0], bclk};
            ssync_q <= {ssync_q[SYNC_STAGES-2:0], sel};
        end
    end

    assign bclk_rise = bsync_q[SYNC_STAGES-1] & ~bsync_q[SYNC_STAGES];

    // Window timer counting down to the evaluation cycle.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || win_q == '0) begin
            win_q <= WIN_W'(WIN_LEN - 1);
        end else begin
            win_q <= win_q - 1'b1;
        end
    end

    assign win_end    = (win_q == '0);
    assign edge_total = {1'b0, edge_q} + {{EDGE_W{1'b0}}, bclk_rise};

    // Edge counter, cleared at each window boundary.
    always_ff @(posedge ref_clk) begin
        if (!rst_n || win_end) begin
            edge_q <= '0;
        end else if (bclk_rise) begin
            edge_q <= edge_q + 1'b1;
        end
    end

    // Threshold comparison with hysteresis, evaluated at window end.
    always_comb begin
        state_d = state_q;
        if (win_end) begin
            if (state_q == PWR_SLEEP && edge_total >= (EDGE_W+1)'(WAKE_CNT)) begin
                state_d = PWR_AWAKE;
            end else if (state_q == PWR_AWAKE && edge_total <= (EDGE_W+1)'(SLEEP_CNT)) begin
                state_d = PWR_SLEEP;
            end
        end
    end

    // Power state register.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            state_q <= PWR_SLEEP;
        end else begin
            state_q <= state_d;
        end
    end

    // Edge-select latch, open only in reset or sleep.
    always_ff @(posedge ref_clk) begin
        if (!rst_n) begin
            sel_lat <= sel;
        end else if (state_q == PWR_SLEEP) begin
            sel_lat <= ssync_q[SYNC_STAGES-1];
        end
    end

    assign awake = (state_q == PWR_AWAKE);

endmodule

// File: rtl/pdm_wake_mute.sv
// Module: bit-clock-domain wake tracking and settle mute.
// Brings the awake flag into the bclk domain and holds a mute for
// MUTE_CYC bit-clock periods after each wake.
// Assumes: awake changes slowly compared to bclk.
module pdm_wake_mute #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MUTE_CYC    = 32
) (
    input  logic bclk,
    input  logic rst_n,
    input  logic awake,
    output logic awake_b,
    output logic mute
);

    localparam int unsigned MUTE_W = $clog2(MUTE_CYC + 1);

    logic [SYNC_STAGES-1:0] async_q;
    logic [MUTE_W-1:0]      mute_q;

    // Synchronizer for the awake flag into the bit-clock domain.
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            async_q <= '0;
        end else begin
            async_q <= {async_q[SYNC_STAGES-2:0], awake};
        end
    end

    assign awake_b = async_q[SYNC_STAGES-1];

    // Mute counter: reloads while asleep, counts periods after wake.
    always_ff @(posedge bclk) begin
        if (!rst_n || !awake_b) begin
            mute_q <= MUTE_W'(MUTE_CYC);
        end else if (mute_q != '0) begin
            mute_q <= mute_q - 1'b1;
        end
    end

    assign mute = (mute_q != '0);

endmodule

// File: rtl/pdm_edge_cell.sv
// Module: one half-cycle drive cell of the output stage.
// On its edge, the owning cell makes its mark differ from the peer
// mark (drive) and the other cell copies the peer mark (release).
// It also captures the data bit when it owns the line.
// Assumes: clk is bclk or its inverse; own is steady while driving.
module pdm_edge_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic own,
    input  logic drive_ok,
    input  logic mute,
    input  logic mod_bit,
    input  logic peer_mark,
    output logic mark,
    output logic dat
);

    // Drive/release marker update on this cell's edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mark <= 1'b0;
        end else if (own && drive_ok) begin
            mark <= ~peer_mark;
        end else begin
            mark <= peer_mark;
        end
    end

    // Data capture on the owning edge, forced low during mute.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dat <= 1'b0;
        end else if (own) begin
            dat <= mod_bit & ~mute;
        end
    end

endmodule

// File: rtl/pdm_out_ctrl.sv
// Module: top of the PDM microphone output controller.
// Joins the activity monitor, the wake mute and two edge cells
// (rising and falling), and gates the line enable with the power state.
// Assumes: rst_n is held long enough to span edges of both clocks.
module pdm_out_ctrl #(
    parameter int unsigned REF_KHZ     = 50000,
    parameter int unsigned WIN_US      = 40,
    parameter int unsigned WAKE_KHZ    = 300,
    parameter int unsigned SLEEP_KHZ   = 70,
    parameter int unsigned MUTE_CYC    = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic sel,
    input  logic mod_bit,
    output logic mod_en,
    output logic pdm_dat,
    output logic pdm_oe
);

    localparam int unsigned N_EDGE = 2;

    logic              awake;
    logic              sel_lat;
    logic              win_end;
    logic              awake_b;
    logic              mute;
    logic [N_EDGE-1:0] mark;
    logic [N_EDGE-1:0] cell_dat;
    logic              oe_raw;
    logic              dat_raw;

    pdm_clk_monitor #(
        .REF_KHZ    (REF_KHZ),
        .WIN_US     (WIN_US),
        .WAKE_KHZ   (WAKE_KHZ),
        .SLEEP_KHZ  (SLEEP_KHZ),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_mon (
        .ref_clk(ref_clk),
        .rst_n  (rst_n),
        .bclk   (bclk),
        .sel    (sel),
        .awake  (awake),
        .sel_lat(sel_lat),
        .win_end(win_end)
    );

    pdm_wake_mute #(
        .SYNC_STAGES(SYNC_STAGES),
        .MUTE_CYC   (MUTE_CYC)
    ) u_mute (
        .bclk   (bclk),
        .rst_n  (rst_n),
        .awake  (awake),
        .awake_b(awake_b),
        .mute   (mute)
    );

    // Cell 0 runs on the rising edge (owned when sel_lat=1),
    // cell 1 on the falling edge (owned when sel_lat=0).
    for (genvar g = 0; g < N_EDGE; g++) begin : g_cell
        logic cclk;
        logic own;
        assign cclk = (g == 0) ? bclk : ~bclk;
        assign own  = (g == 0) ? sel_lat : ~sel_lat;

        pdm_edge_cell u_cell (
            .clk      (cclk),
            .rst_n    (rst_n),
            .own      (own),
            .drive_ok (awake_b),
            .mute     (mute),
            .mod_bit  (mod_bit),
            .peer_mark(mark[N_EDGE-1-g]),
            .mark     (mark[g]),
            .dat      (cell_dat[g])
        );
    end

    assign oe_raw  = mark[0] ^ mark[1];
    assign dat_raw = sel_lat ? cell_dat[0] : cell_dat[1];
    assign mod_en  = awake;
    assign pdm_oe  = oe_raw & awake;
    assign pdm_dat = pdm_oe & dat_raw;

endmodule

// File: rtl/pdm_out_ctrl_chk.sv
// Checker: temporal properties of pdm_out_ctrl, bound to every instance.
module pdm_out_ctrl_chk (
    input logic ref_clk,
    input logic rst_n,
    input logic bclk,
    input logic mod_en,
    input logic sel_lat,
    input logic win_end,
    input logic oe_raw,
    input logic awake_b,
    input logic mute
);

    // R8
    sel_frozen_awake_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mod_en && $past(mod_en)) |-> $stable(sel_lat));

    // R2 R3 R4
    pwr_step_at_window_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (mod_en != $past(mod_en)) |-> $past(win_end));

    // R5
    fall_owner_release_chk: assert property (@(negedge bclk) disable iff (!rst_n)
        (!sel_lat && $stable(sel_lat)) |-> !oe_raw);

    // R6
    rise_owner_release_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (sel_lat && $stable(sel_lat)) |-> !oe_raw);

    // R7
    mute_on_wake_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        $rose(awake_b) |-> mute);

endmodule

bind pdm_out_ctrl pdm_out_ctrl_chk u_chk (
    .ref_clk(ref_clk),
    .rst_n  (rst_n),
    .bclk   (bclk),
    .mod_en (mod_en),
    .sel_lat(sel_lat),
    .win_end(win_end),
    .oe_raw (oe_raw),
    .awake_b(awake_b),
    .mute   (mute)
);

// File: tb/sim_pdm_out_ctrl.sv
`timescale 1ns/1ps
module sim_pdm_out_ctrl;

    localparam int WIN_US    = 40;
    localparam int WAKE_KHZ  = 300;
    localparam int SLEEP_KHZ = 70;
    localparam int MUTE      = 32;

    logic ref_clk = 1'b0;
    logic rst_n   = 1'b0;
    logic bclk    = 1'b0;
    logic sel     = 1'b0;
    logic mod_bit = 1'b0;
    logic mod_en, pdm_dat, pdm_oe;

    int   bhalf   = 200;
    bit   sel_exp = 1'b0;
    int   n_cmp   = 0;
    int   n_bad   = 0;

    pdm_out_ctrl #(
        .REF_KHZ(50000), .WIN_US(WIN_US), .WAKE_KHZ(WAKE_KHZ),
        .SLEEP_KHZ(SLEEP_KHZ), .MUTE_CYC(MUTE), .SYNC_STAGES(2)
    ) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .bclk(bclk), .sel(sel),
        .mod_bit(mod_bit), .mod_en(mod_en), .pdm_dat(pdm_dat), .pdm_oe(pdm_oe)
    );

    always #10 ref_clk = ~ref_clk;

    // Bit clock generator; bhalf==0 parks the clock low.
    initial begin
        forever begin
            if (bhalf == 0) begin
                bclk = 1'b0;
                #100;
            end else begin
                #(bhalf) bclk = ~bclk;
            end
        end
    end

    // Expected power state after a window with the given edge rate.
    function automatic bit exp_pwr(input bit cur, input int khz);
        int edges;
        edges = (khz * WIN_US) / 1000;
        if (!cur && edges >= (WAKE_KHZ * WIN_US) / 1000) return 1'b1;
        if (cur && edges <= (SLEEP_KHZ * WIN_US) / 1000) return 1'b0;
        return cur;
    endfunction

    // Expected line value for a driven period.
    function automatic bit exp_bit(input bit muted, input bit b);
        return muted ? 1'b0 : b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_pwr(input bit val, input int max_cyc);
        for (int i = 0; i < max_cyc; i++) begin
            @(posedge ref_clk);
            if (mod_en === val) break;
        end
        #5;
    endtask

    task automatic owner_edge();
        if (sel_exp) @(posedge bclk); else @(negedge bclk);
    endtask

    task automatic other_edge();
        if (sel_exp) @(negedge bclk); else @(posedge bclk);
    endtask

    // Random data periods: release on the other edge, live bit on the owner edge.
    task automatic run_cycles(input int n);
        bit b;
        for (int i = 0; i < n; i++) begin
            other_edge();
            #50;
            check(sel_exp ? "R6 release" : "R5 release", int'(pdm_oe), 0);
            #50;
            b = 1'($urandom % 2);
            mod_bit = b;
            owner_edge();
            #50;
            check(sel_exp ? "R6 drive" : "R5 drive", int'(pdm_oe), 1);
            check("R9 data", int'(pdm_dat), int'(exp_bit(1'b0, b)));
        end
    endtask

    // Wake, then count driven periods that read 0 while mod_bit is held at 1.
    task automatic wake_and_mute(input int khz);
        int muted;
        muted = 0;
        mod_bit = 1'b1;
        wait_pwr(1'b1, 10000);
        check("R2 wake", int'(mod_en), int'(exp_pwr(1'b0, khz)));
        for (int i = 0; i < 200; i++) begin
            owner_edge();
            #50;
            if (pdm_oe) begin
                if (pdm_dat == exp_bit(1'b1, 1'b1)) muted++;
                else break;
            end
        end
        check("R7 mute periods", muted, MUTE);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #4ms;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (60) @(posedge ref_clk);
        #5;
        check("R1 mod_en in reset", int'(mod_en), 0);
        check("R1 oe in reset", int'(pdm_oe), 0);
        rst_n = 1'b1;
        repeat (3) @(posedge ref_clk);
        #5;
        check("R1 mod_en after reset", int'(mod_en), 0);
        check("R1 oe after reset", int'(pdm_oe), 0);

        // 2.5 MHz, falling-edge owner
        wake_and_mute(2500);
        run_cycles(40);

        // R8: sel changes while awake, ownership stays
        sel = 1'b1;
        run_cycles(30);

        // R3: stopped clock
        bhalf = 0;
        wait_pwr(1'b0, 10000);
        check("R3 sleep on stopped clock", int'(mod_en), int'(exp_pwr(1'b1, 0)));
        check("R3 oe released in sleep", int'(pdm_oe), 0);
        sel_exp = 1'b1;

        // R4: 150 kHz while asleep holds sleep
        bhalf = 3333;
        repeat (10000) @(posedge ref_clk);
        #5;
        check("R4 hold sleep", int'(mod_en), int'(exp_pwr(1'b0, 150)));

        // 4 MHz, rising-edge owner now latched
        bhalf = 125;
        wake_and_mute(4000);
        run_cycles(40);

        // R4: 150 kHz while awake holds awake
        bhalf = 3333;
        repeat (10000) @(posedge ref_clk);
        #5;
        check("R4 hold awake", int'(mod_en), int'(exp_pwr(1'b1, 150)));

        // R3: 25 kHz goes to sleep
        bhalf = 20000;
        wait_pwr(1'b0, 12000);
        check("R3 sleep on slow clock", int'(mod_en), int'(exp_pwr(1'b1, 25)));
        check("R3 oe off on slow clock", int'(pdm_oe), 0);

        // R2: 400 kHz wakes
        bhalf = 1250;
        wait_pwr(1'b1, 10000);
        check("R2 wake at 400 kHz", int'(mod_en), int'(exp_pwr(1'b0, 400)));
        repeat (MUTE + 4) owner_edge();
        run_cycles(8);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule